// File: doc/BRIEF.md
# Acknowledged Single-Event Clock-Domain Crossing

This block carries one control event at a time from a source clock domain into an unrelated destination clock domain, and no accepted event is ever lost, whatever the two clock frequencies are. When the source raises `src_event` while the block is idle, the event is accepted. A registered request level then crosses into the destination domain. There it passes through a flip-flop synchronizer, and its rising edge produces a single-cycle `dst_pulse`.

The synchronized request level is registered as an acknowledge and returned through a matching synchronizer. The source drops its request only after that acknowledge arrives. It then waits for the acknowledge to fall again before it takes the next event, which completes a four-phase handshake.

`src_busy` tells the source when a new event would be ignored. The synchronizer depth is a parameter: two stages for ordinary use, three for high-speed designs that need a longer mean time between failures.

Top module: `cdc_ack_event_sync`

## Requirements
- R1: While its domain's synchronous active-low reset is low, and on the first cycle after release, `src_busy` reads 0 and `dst_pulse` reads 0. Every request, acknowledge and synchronizer flop is cleared to 0.
- R2: When `src_event` is 1 at a source clock edge with `src_busy` 0, the event is accepted. From that edge on, `src_busy` reads 1 and the crossing request is 1.
- R3: An event presented while `src_busy` is 1 is ignored. It produces no request and no destination pulse.
- R4: Every accepted event produces exactly one `dst_pulse`, with fast-to-slow, slow-to-fast and near-equal clock ratios. The pulse marks the rising edge of the synchronized request, so the pulse count never exceeds the number of accepted events.
- R5: `dst_pulse` is exactly one destination clock cycle wide.
- R6: Once raised, the crossing request stays high until the synchronized acknowledge is seen high in the source domain. The request comes directly from a source-domain flip-flop.
- R7: Each crossing level, the request in the destination domain and the acknowledge in the source domain, is held high for at least three consecutive edges of the receiving clock.
- R8: After the request drops, `src_busy` falls only once the synchronized acknowledge reads 0. A further event is then accepted again.
- R9: Parameter `SYNC_STAGES` sets the depth of both synchronizers. The value 2 and the value 3 both meet R2 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain synchronous active-low reset |
| src_event | input | 1 | Event request from the source domain, sampled on `src_clk` |
| src_busy | output | 1 | High from acceptance until the handshake has fully returned |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain synchronous active-low reset |
| dst_pulse | output | 1 | One-cycle pulse in the destination domain per accepted event |

## Verification
The hardest case to reach is an event that lands exactly on the source edge where `src_busy` falls, while the destination clock runs much slower or much faster than the source clock. In that case the acceptance decision and the draining acknowledge meet in the same cycle.

The stimulus holds `src_event` high for long bursts, so some acceptance is certain to fall on that release edge. It repeats this with the destination period both above and below the source period, and it runs a two-stage and a three-stage instance side by side. A behavioural model counts accepted events from the port values before each source edge and compares that count against the destination pulses on every destination cycle.

// File: rtl/cdc_hs_pkg.sv
// Package: shared types and constants for the acknowledged event crossing.
// Assumes: nothing beyond IEEE 1800-2017 synthesis subset.
package cdc_hs_pkg;

    // Source-side handshake phases of the four-phase protocol.
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_REQ   = 2'd1,
        HS_DRAIN = 2'd2
    } hs_state_e;

    // Minimum number of receiving-clock edges a crossing level must hold.
    localparam int MIN_HOLD_EDGES = 3;

    // Width of the run-length counters used by the stability checks.
    localparam int RUN_W = 8;

endpackage

// File: rtl/hs_sync_chain.sv
// Module: hs_sync_chain
// Resynchronizes one asynchronous level into the local clock through a
// chain of STAGES flip-flops. Each stage gets one full local cycle to
// resolve before the next stage samples it.
// Assumes: d_async comes straight from a flop in the sending domain and
// holds each level long enough (checked below).
module hs_sync_chain
    import cdc_hs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] stg;

    // First stage: capture the asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= 1'b0;
        else        stg[0] <= d_async;
    end

    // Remaining stages: one resolution cycle per stage.
    for (genvar g = 1; g < N; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= 1'b0;
            else        stg[g] <= stg[g-1];
        end
    end

    assign q_sync = stg[N-1];

    // Checker support: count consecutive high samples of the first stage.
    logic [RUN_W-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n)             hi_run <= '0;
        else if (!stg[0])       hi_run <= '0;
        else if (hi_run != '1)  hi_run <= hi_run + 1'b1;
    end

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stg[0]) |-> (hi_run >= RUN_W'(MIN_HOLD_EDGES)));

endmodule

// File: rtl/hs_src_ctrl.sv
// Module: hs_src_ctrl
// Source side of the four-phase handshake. Accepts an event when idle,
// raises a registered request, drops it when the synchronized acknowledge
// is high, then waits for the acknowledge to fall before going idle.
// Assumes: ack_sync is already synchronized into this clock domain.
module hs_src_ctrl
    import cdc_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic ack_sync,
    output logic req_o,
    output logic busy_o
);

    hs_state_e st_q, st_nxt;
    logic      req_q;

    // Next-phase selection of the handshake.
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            HS_IDLE:  if (event_i)   st_nxt = HS_REQ;
            HS_REQ:   if (ack_sync)  st_nxt = HS_DRAIN;
            HS_DRAIN: if (!ack_sync) st_nxt = HS_IDLE;
            default:                 st_nxt = HS_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HS_IDLE;
        else        st_q <= st_nxt;
    end

    // Request flop: the only source of the crossing signal.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= (st_nxt == HS_REQ);
    end

    assign req_o  = req_q;
    assign busy_o = (st_q != HS_IDLE);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && event_i) |=> (busy_o && req_o));

    // R3
    idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> !$past(busy_o));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_sync) |=> req_o);

    // R8
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (!ack_sync && !req_o));

endmodule

// File: rtl/hs_dst_ctrl.sv
// Module: hs_dst_ctrl
// Destination side: synchronizes the request, emits a one-cycle pulse on
// its rising edge, and returns the synchronized level as a registered
// acknowledge.
// Assumes: req_async is driven by a flop in the source domain.
module hs_dst_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic ack_o,
    output logic pulse_o
);

    logic req_s;
    logic seen_q;
    logic pulse_q;

    hs_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (req_async),
        .q_sync  (req_s)
    );

    // Acknowledge flop: registered copy of the synchronized request.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= req_s;
    end

    // Pulse flop: rising edge of the synchronized request.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= req_s & ~seen_q;
    end

    assign ack_o   = seen_q;
    assign pulse_o = pulse_q;

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    // R4
    pulse_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (ack_o && !$past(ack_o)));

endmodule

// File: rtl/cdc_ack_event_sync.sv
// Module: cdc_ack_event_sync (top)
// Closed-loop crossing of single control events between two unrelated
// clocks. Source control, destination control, and the acknowledge
// synchronizer back into the source domain.
// Assumes: each reset is synchronous to its own clock and held for
// several cycles of that clock.
module cdc_ack_event_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_event,
    output logic src_busy,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);

    logic req_x;
    logic ack_x;
    logic ack_s;

    hs_src_ctrl u_src (
        .clk      (src_clk),
        .rst_n    (src_rst_n),
        .event_i  (src_event),
        .ack_sync (ack_s),
        .req_o    (req_x),
        .busy_o   (src_busy)
    );

    hs_dst_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_dst (
        .clk       (dst_clk),
        .rst_n     (dst_rst_n),
        .req_async (req_x),
        .ack_o     (ack_x),
        .pulse_o   (dst_pulse)
    );

    hs_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (src_clk),
        .rst_n   (src_rst_n),
        .d_async (ack_x),
        .q_sync  (ack_s)
    );

endmodule

// File: tb/cdc_ack_event_sync_bench.sv
`timescale 1ns/100ps
module cdc_ack_event_sync_bench;

    logic src_clk = 1'b0;
    logic dst_clk = 1'b0;
    logic src_rst_n = 1'b0;
    logic dst_rst_n = 1'b0;
    logic src_event = 1'b0;
    logic [1:0] busy;
    logic [1:0] pulse;
    real dst_half = 7.0;

    int checks = 0;
    int errors = 0;
    int acc [2] = '{0, 0};
    int pcount [2] = '{0, 0};
    logic [1:0] pend = 2'b00;
    logic [1:0] prev_pulse = 2'b00;
    bit run_mon = 1'b0;
    bit done = 1'b0;

    always #2.0 src_clk = ~src_clk;
    always #(dst_half) dst_clk = ~dst_clk;

    cdc_ack_event_sync u_cdc_ack_event_sync (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_event(src_event),
        .src_busy(busy[0]), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .dst_pulse(pulse[0])
    );

    cdc_ack_event_sync #(.SYNC_STAGES(3)) u_cdc_ack_event_sync_s3 (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_event(src_event),
        .src_busy(busy[1]), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .dst_pulse(pulse[1])
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Source-side model: count accepted events (R2, R3, R9).
    always @(negedge src_clk) begin
        #0.5;
        if (run_mon) begin
            for (int i = 0; i < 2; i++) begin
                if (pend[i]) begin
                    acc[i]++;
                    check(busy[i] == 1'b1, "R2 busy after acceptance", int'(busy[i]), 1);
                end
                pend[i] = src_event && !busy[i];
            end
        end
    end

    // Destination-side model: pulse width and count bound (R4, R5).
    always @(negedge dst_clk) begin
        if (run_mon) begin
            for (int i = 0; i < 2; i++) begin
                if (pulse[i]) begin
                    pcount[i]++;
                    check(!prev_pulse[i], "R5 pulse one cycle wide", 2, 1);
                    check(pcount[i] <= acc[i], "R4 pulses not above accepted", pcount[i], acc[i]);
                end
                prev_pulse[i] = pulse[i];
            end
        end
    end

    task automatic one_event();
        @(negedge src_clk);
        src_event = 1'b1;
        @(negedge src_clk);
        src_event = 1'b0;
    endtask

    task automatic burst(input int n);
        @(negedge src_clk);
        src_event = 1'b1;
        repeat (n) @(negedge src_clk);
        src_event = 1'b0;
    endtask

    // Wait for both instances to go idle; R8 bound on handshake return.
    task automatic wait_idle();
        int n = 0;
        int quiet = 0;
        while (quiet < 4 && n < 600) begin
            @(negedge src_clk);
            #1.0;
            if (busy == 2'b00) quiet++;
            else quiet = 0;
            n++;
        end
        check(quiet >= 4, "R8 busy returns low", int'(busy), 0);
        repeat (10) @(negedge dst_clk);
    endtask

    task automatic compare_counts(input string tag);
        for (int i = 0; i < 2; i++)
            check(pcount[i] == acc[i], tag, pcount[i], acc[i]);
    endtask

    initial begin
        // Watchdog.
        #600us;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        real halves [4] = '{7.0, 1.3, 2.3, 0.9};
        repeat (12) @(negedge src_clk);
        // R1: outputs quiet during reset.
        check(busy == 2'b00, "R1 busy in reset", int'(busy), 0);
        check(pulse == 2'b00, "R1 pulse in reset", int'(pulse), 0);
        @(negedge src_clk);
        src_rst_n = 1'b1;
        @(negedge dst_clk);
        dst_rst_n = 1'b1;
        @(negedge src_clk);
        #1.0;
        check(busy == 2'b00, "R1 busy after release", int'(busy), 0);
        check(pulse == 2'b00, "R1 pulse after release", int'(pulse), 0);
        run_mon = 1'b1;

        for (int r = 0; r < 4; r++) begin
            dst_half = halves[r];
            repeat (4) @(negedge dst_clk);
            // R2, R4: isolated events.
            for (int k = 0; k < 4; k++) begin
                one_event();
                wait_idle();
            end
            compare_counts("R4 isolated events, one pulse each");
            // R3, R8: long burst, events during busy ignored, release-edge acceptance.
            burst(60 + 7 * r);
            wait_idle();
            compare_counts("R3 burst while busy ignored");
            // Two events closer than one handshake.
            one_event();
            repeat (2) @(negedge src_clk);
            one_event();
            wait_idle();
            compare_counts("R9 both depths agree with model");
        end

        check(acc[0] > 20, "R4 enough accepted events s2", acc[0], 21);
        check(acc[1] > 20, "R4 enough accepted events s3", acc[1], 21);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule